// File: doc/BRIEF.md
# Three-Channel Watchdog Timer

This block holds three independent watchdog channels behind a small register bus. Each channel has a 16-bit down counter and a limit register. A shared prescaler divides the system clock into a 100 ms tick, and each running counter steps down by one on every tick. Software starts a channel by writing its limit. It keeps the channel alive by reading the channel's counter, which returns the count and reloads it from the limit in the same access.

When a running counter reaches zero, the channel stops and latches its expired flag. It then fires an action that is fixed per channel: channel 0 raises a level interrupt, channel 1 pulses a CPU-only reset, and channel 2 pulses a full board reset. A shared three-bit disable mask can block any channel's action. A masked channel still counts and still reports expiry.

Halfword registers travel little-endian on a big-endian bus. The low byte of a value sits in data bits 15:8 and is enabled by byte enable bit 1. The high byte sits in bits 7:0 and is enabled by byte enable bit 0. Byte registers use bits 7:0 with byte enable bit 0.

Top module: `wdt_trio`

## Requirements
- R1: After reset, every counter and every limit hold 1, every status reads 0, the mask reads 0, and all three action outputs are low.
- R2: A write to a channel's limit (window offset +0x4) stores the enabled bytes. The value's low byte comes from data[15:8] under be[1] and its high byte from data[7:0] under be[0]. The write loads the counter with the new limit, sets running and clears expired. A read of the limit returns it byte-swapped and has no side effect.
- R3: A running counter decrements once every TICK_CLKS clocks. A counter started at N expires on the Nth tick after the write, which clears running and sets expired.
- R4: A read at a channel's counter (offset +0x0) returns the current count byte-swapped and reloads the counter from the limit. A write to the counter address is ignored.
- R5: The status byte (offset +0x8) has bit 0 = running and bit 1 = expired, with bits 15:2 zero. Expired stays set until the next limit write. Running and expired are never set together.
- R6: The mask register at 0x30 keeps data[2:0] under be[0] and reads back with bits 15:3 zero. A set bit n blocks channel n's action, but the channel keeps counting and still sets expired.
- R7: Channel 0 expiry with mask bit 0 clear raises irq_o. irq_o stays high until a channel 0 limit write or a set mask bit 0 clears it.
- R8: Unmasked expiry of channel 1 drives cpu_rst_o high for exactly PULSE_W clocks. Unmasked expiry of channel 2 drives brd_rst_o high for exactly PULSE_W clocks. Each action appears only on its own output.
- R9: When accesses coincide with a tick, a limit write takes priority over a counter-read reload, and a reload takes priority over the tick. A keep-alive read or limit write in the expiring tick's cycle prevents the expiry.
- R10: Channel windows start at 0x00, 0x10 and 0x20. Addresses 0x30 and above, other than the mask register, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access; counter reads reload |
| be_i | input | 2 | Byte lane enables for writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle rd_en_i is high, else 0 |
| irq_o | output | 1 | Channel 0 expiry interrupt, level |
| cpu_rst_o | output | 1 | Channel 1 expiry CPU reset pulse |
| brd_rst_o | output | 1 | Channel 2 expiry board reset pulse |

## Verification
A channel's expiring tick can fall in the same clock as a keep-alive read or a limit write to that channel. The bench recomputes the prescaler phase from the clock edges it has counted since reset release. It then places the read or the write exactly on the edge of the tick that would take the counter from 1 to 0. It judges the result by the read data of that access, the status byte right afterwards (still running, not expired) and irq_o staying low, and for the write case by expiry arriving only after the full new limit of ticks.

// File: rtl/wdt_trio_pkg.sv
package wdt_trio_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_LIM  = 2'd1,
    REG_STAT = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam logic [5:0] MASK_ADDR = 6'h30;

  // bus carries halfwords with bytes swapped
  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int unsigned TICK_CLKS = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_chan.sv
module wdt_chan
  import wdt_trio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_lim_i,
  input  logic [CNT_W-1:0] lim_val_i,
  input  logic [1:0]       lim_be_i,   // [0] low byte, [1] high byte of value
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             run_o,
  output logic             exp_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, lim_q, lim_nxt;
  logic             run_q, exp_q;
  logic             last_step;

  always_comb begin
    lim_nxt = lim_q;
    if (lim_be_i[0]) lim_nxt[7:0]       = lim_val_i[7:0];
    if (lim_be_i[1]) lim_nxt[CNT_W-1:8] = lim_val_i[CNT_W-1:8];
  end

  assign last_step = (cnt_q <= CNT_W'(1));
  assign expire_o  = tick_i & run_q & last_step & ~ld_lim_i & ~reload_i;

  // priority: limit write, then keep-alive reload, then tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
      lim_q <= CNT_W'(1);
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (ld_lim_i) begin
      lim_q <= lim_nxt;
      cnt_q <= lim_nxt;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q <= lim_q;
    end else if (tick_i && run_q) begin
      if (last_step) begin
        cnt_q <= '0;
        run_q <= 1'b0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign run_o = run_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(PULSE_W + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         left_q <= '0;
    else if (fire_i)     left_q <= CW'(PULSE_W);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_trio.sv
module wdt_trio
  import wdt_trio_pkg::*;
#(
  parameter int unsigned TICK_CLKS = 5_000_000,
  parameter int unsigned PULSE_W   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        brd_rst_o
);
  logic             tick;
  logic [1:0]       win;
  reg_sel_e         sel;
  logic             word_ok, mask_hit;
  logic [CNT_W-1:0] wval;
  logic [1:0]       vbe;
  logic [NUM_CH-1:0] ld_lim, reload, ch_run, ch_exp, expire;
  logic [CNT_W-1:0] ch_cnt [NUM_CH];
  logic [CNT_W-1:0] ch_lim [NUM_CH];
  logic [NUM_CH-1:0] mask_q;
  logic             irq_q;

  assign win      = addr_i[5:4];
  assign sel      = reg_sel_e'(addr_i[3:2]);
  assign word_ok  = (addr_i[1:0] == 2'b00);
  assign mask_hit = (addr_i == MASK_ADDR);
  assign wval     = swap16(wdata_i);
  assign vbe      = {be_i[0], be_i[1]};

  wdt_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ld_lim[i] = wr_en_i && (|be_i) && word_ok && (win == 2'(i)) && (sel == REG_LIM);
    assign reload[i] = rd_en_i && word_ok && (win == 2'(i)) && (sel == REG_CNT);

    wdt_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .ld_lim_i (ld_lim[i]),
      .lim_val_i(wval),
      .lim_be_i (vbe),
      .reload_i (reload[i]),
      .cnt_o    (ch_cnt[i]),
      .lim_o    (ch_lim[i]),
      .run_o    (ch_run[i]),
      .exp_o    (ch_exp[i]),
      .expire_o (expire[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mask_q <= '0;
    else if (wr_en_i && be_i[0] && mask_hit) mask_q <= wdata_i[NUM_CH-1:0];
  end

  // channel 0: level interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (expire[0] | (irq_q & ~ld_lim[0])) & ~mask_q[0];
  end
  assign irq_o = irq_q;

  // channels 1 and 2: reset pulses
  wdt_pulse #(.PULSE_W(PULSE_W)) u_cpu_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (expire[1] & ~mask_q[1]),
    .pulse_o(cpu_rst_o)
  );

  wdt_pulse #(.PULSE_W(PULSE_W)) u_brd_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (expire[2] & ~mask_q[2]),
    .pulse_o(brd_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (mask_hit) begin
        rdata_o = {{(16-NUM_CH){1'b0}}, mask_q};
      end else if (word_ok) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (win == 2'(i)) begin
            case (sel)
              REG_CNT:  rdata_o = swap16(ch_cnt[i]);
              REG_LIM:  rdata_o = swap16(ch_lim[i]);
              REG_STAT: rdata_o = {14'b0, ch_exp[i], ch_run[i]};
              default:  rdata_o = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdt_trio_chk.sv
module wdt_trio_chk #(
  parameter int unsigned PULSE_W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] addr_i,
  input logic       wr_en_i,
  input logic [1:0] be_i,
  input logic       irq_o,
  input logic       cpu_rst_o,
  input logic       brd_rst_o,
  input logic [2:0] mask_q,
  input logic [2:0] ch_run,
  input logic [2:0] ch_exp
);
  logic [15:0] cpu_hi, brd_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_hi <= '0;
      brd_hi <= '0;
    end else begin
      cpu_hi <= cpu_rst_o ? ((cpu_hi == 16'hFFFF) ? cpu_hi : cpu_hi + 1'b1) : '0;
      brd_hi <= brd_rst_o ? ((brd_hi == 16'hFFFF) ? brd_hi : brd_hi + 1'b1) : '0;
    end
  end

  // R8
  cpu_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> (cpu_hi == 16'(PULSE_W)));
  // R8
  brd_pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brd_rst_o |-> (brd_hi < 16'(PULSE_W)));
  // R6
  cpu_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> !$past(mask_q[1]));
  // R7
  irq_lim_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 6'h04 && be_i != 2'b00) |=> !irq_o);
  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !$past(mask_q[0]));
  // R5
  run_exp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_run & ch_exp) == 3'b000);
endmodule

bind wdt_trio wdt_trio_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .be_i     (be_i),
  .irq_o    (irq_o),
  .cpu_rst_o(cpu_rst_o),
  .brd_rst_o(brd_rst_o),
  .mask_q   (mask_q),
  .ch_run   (ch_run),
  .ch_exp   (ch_exp)
);

// File: tb/wdt_trio_tb.sv
module wdt_trio_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 8;
  localparam int PW   = 4;
  localparam int NV   = 15;

  // {is_write, addr, be, data, expected}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 6'h00, 2'b11, 16'h0000, 16'h0100},
    {1'b0, 6'h04, 2'b11, 16'h0000, 16'h0100},
    {1'b0, 6'h08, 2'b11, 16'h0000, 16'h0000},
    {1'b0, 6'h14, 2'b11, 16'h0000, 16'h0100},
    {1'b0, 6'h28, 2'b11, 16'h0000, 16'h0000},
    {1'b0, 6'h30, 2'b11, 16'h0000, 16'h0000},
    {1'b1, 6'h24, 2'b11, 16'h3412, 16'h0000},
    {1'b0, 6'h24, 2'b11, 16'h0000, 16'h3412},
    {1'b1, 6'h24, 2'b10, 16'hAB00, 16'h0000},
    {1'b0, 6'h24, 2'b11, 16'h0000, 16'hAB12},
    {1'b1, 6'h24, 2'b01, 16'h0077, 16'h0000},
    {1'b0, 6'h24, 2'b11, 16'h0000, 16'hAB77},
    {1'b0, 6'h28, 2'b11, 16'h0000, 16'h0001},
    {1'b1, 6'h30, 2'b01, 16'h00FF, 16'h0000},
    {1'b0, 6'h30, 2'b11, 16'h0000, 16'h0007}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, cpu_rst_o, brd_rst_o;

  int total = 0;
  int bad = 0;
  int edge_n = 0;
  int cpu_hi = 0;
  int brd_hi = 0;
  bit done = 0;

  wdt_trio #(.TICK_CLKS(TICK), .PULSE_W(PW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .brd_rst_o(brd_rst_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (!rst_ni) edge_n <= 0;
    else         edge_n <= edge_n + 1;
    if (cpu_rst_o) cpu_hi <= cpu_hi + 1;
    if (brd_rst_o) brd_hi <= brd_hi + 1;
  end

  function automatic logic [15:0] swp(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [1:0] b, input logic [15:0] d);
    addr_i = a; be_i = b; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; be_i = '0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  // stop at the negedge before a tick edge
  task automatic to_pre_tick();
    while (((edge_n + 1) % TICK) != 0) @(negedge clk_i);
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      to_pre_tick();
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c0, b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 outputs low after reset
    chk("R1", {13'b0, irq_o, cpu_rst_o, brd_rst_o}, 16'h0);

    // R1 R2 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) bus_wr(VEC[i][39:34], VEC[i][33:32], VEC[i][31:16]);
      else            rd_chk("R1/R2/R5/R6 table", VEC[i][39:34], VEC[i][15:0]);
    end
    bus_wr(6'h30, 2'b01, 16'h0000);
    rd_chk("R6 mask clear", 6'h30, 16'h0000);
    // R10 unused address
    rd_chk("R10", 6'h34, 16'h0000);

    // R4 counter write ignored (ch1 stopped, count 1)
    bus_wr(6'h10, 2'b11, 16'h3412);
    rd_chk("R4 cnt write ignored", 6'h10, 16'h0100);
    rd_chk("R5 stopped status", 6'h18, 16'h0000);

    // R3 R7 expiry after N ticks
    bus_wr(6'h04, 2'b11, swp(16'd3));
    wait_ticks(2);
    rd_chk("R3 still running", 6'h08, 16'h0001);
    wait_ticks(1);
    rd_chk("R3 expired", 6'h08, 16'h0002);
    chk("R7 irq set", {15'b0, irq_o}, 16'h1);
    bus_wr(6'h04, 2'b11, 16'hFFFF);
    chk("R7 irq cleared by limit write", {15'b0, irq_o}, 16'h0);
    rd_chk("R2 limit write clears expired", 6'h08, 16'h0001);

    // R4 keep-alive read
    bus_wr(6'h04, 2'b11, swp(16'd3));
    wait_ticks(2);
    rd_chk("R4 read returns count", 6'h00, swp(16'd1));
    wait_ticks(2);
    rd_chk("R4 reload delays expiry", 6'h08, 16'h0001);
    wait_ticks(1);
    rd_chk("R4 expires after reload", 6'h08, 16'h0002);
    chk("R7 irq set again", {15'b0, irq_o}, 16'h1);
    bus_wr(6'h30, 2'b01, 16'h0001);
    @(negedge clk_i);
    chk("R7 irq cleared by mask", {15'b0, irq_o}, 16'h0);
    bus_wr(6'h30, 2'b01, 16'h0000);
    @(negedge clk_i);
    chk("R7 irq stays low after unmask", {15'b0, irq_o}, 16'h0);

    // R9 keep-alive read on the expiring tick
    bus_wr(6'h04, 2'b11, swp(16'd2));
    wait_ticks(1);
    to_pre_tick();
    rd_chk("R9 read on tick value", 6'h00, swp(16'd1));
    rd_chk("R9 read beats tick", 6'h08, 16'h0001);
    chk("R9 no irq", {15'b0, irq_o}, 16'h0);

    // R9 limit write on the expiring tick
    wait_ticks(1);
    to_pre_tick();
    bus_wr(6'h04, 2'b11, swp(16'd5));
    rd_chk("R9 write beats tick", 6'h08, 16'h0001);
    wait_ticks(4);
    rd_chk("R9 full new limit", 6'h08, 16'h0001);
    wait_ticks(1);
    rd_chk("R9 expiry after new limit", 6'h08, 16'h0002);
    bus_wr(6'h04, 2'b11, 16'hFFFF);

    // R6 masked channel 1 counts but takes no action
    c0 = cpu_hi;
    bus_wr(6'h30, 2'b01, 16'h0002);
    bus_wr(6'h14, 2'b11, swp(16'd3));
    wait_ticks(1);
    rd_chk("R6 masked keeps counting", 6'h10, swp(16'd2));
    wait_ticks(3);
    rd_chk("R6 masked sets expired", 6'h18, 16'h0002);
    repeat (PW + 2) @(negedge clk_i);
    chk("R6 masked no cpu reset", 16'(cpu_hi - c0), 16'h0);
    bus_wr(6'h30, 2'b01, 16'h0000);

    // R8 channel 1 pulse
    c0 = cpu_hi; b0 = brd_hi;
    bus_wr(6'h14, 2'b11, swp(16'd2));
    wait_ticks(2);
    chk("R8 cpu reset asserted", {15'b0, cpu_rst_o}, 16'h1);
    repeat (PW + 2) @(negedge clk_i);
    chk("R8 cpu pulse width", 16'(cpu_hi - c0), 16'(PW));
    chk("R8 no board reset from ch1", 16'(brd_hi - b0), 16'h0);
    chk("R8 no irq from ch1", {15'b0, irq_o}, 16'h0);

    // R8 channel 2 pulse
    c0 = cpu_hi; b0 = brd_hi;
    bus_wr(6'h24, 2'b11, swp(16'd1));
    wait_ticks(1);
    chk("R8 board reset asserted", {15'b0, brd_rst_o}, 16'h1);
    repeat (PW + 2) @(negedge clk_i);
    chk("R8 board pulse width", 16'(brd_hi - b0), 16'(PW));
    chk("R8 no cpu reset from ch2", 16'(cpu_hi - c0), 16'h0);

    finish_run();
  end
endmodule